// File: doc/BRIEF.md
# Core module control register bank

This block is the housekeeping register file of a processor core module. A host reaches it over a simple 32-bit register bus with word-indexed addresses. Through it, software sets the module's clock and memory configuration words, drives a status LED, and moves the boot flash away from address zero. It can also pulse a system reset request, keep two sets of general-purpose flags, and run a one-source local interrupt that can be routed to an IRQ line, a FIQ line or both.

The configuration words are protected by a 16-bit unlock key held in a lock word. Word indices 64 to 127 form a read-only window onto a memory-module descriptor table. Each word returns one table byte, zero-extended. The byte that encodes installed memory size is derived from a build parameter. A read returns its data on `rdata` in the cycle after `rd_en` is sampled. A write takes effect at the clock edge where `wr_en` is sampled.

Top module: `cm_ctrl_regs`

## Requirements
- R1: After reset, the config words read as follows: word 1 reads 0x01000048, word 7 reads 0x0007FEFF, word 8 reads 0x00011122 and word 9 reads 0x00000112. The lock, control, flags, enables and interrupt level are zero. The `led`, `remap`, `sys_rst_req`, `irq` and `fiq` outputs are low.
- R2: A write to word 5 stores only data bits 15:0 as the key. A read of word 5 returns the key in bits 15:0, with bit 16 set exactly when the key equals 0xA05F.
- R3: Words 1, 7, 8 and 9 accept a write only while the stored key equals 0xA05F. At any other time the write is ignored and a read returns the old value.
- R4: A write to word 3 stores data bits 0 and 2. `led` follows bit 0 and `remap` follows bit 2 from the cycle after the write. A read of word 3 returns those two bits with every other bit zero.
- R5: A write to word 3 with data bit 3 set makes `sys_rst_req` high for exactly the next cycle. Bit 3 always reads back as zero.
- R6: A write to word 12 ORs the data into flag set A. A write to word 13 clears every flag-A bit written as 1. Words 14 and 15 do the same for flag set B. Reads of words 12 and 14 return flag set A and flag set B.
- R7: A write to word 18 ORs the data into the IRQ enable mask. A write to word 19 clears the enable bits written as 1. A read of word 18 returns the mask, word 17 returns the raw level, and word 16 returns the level AND the mask.
- R8: The level is a single bit at bit 0. A write to word 20 with data bit 0 set raises it. A write to word 21 with data bit 0 set lowers it. Other data bits have no effect. A read of word 20 returns the level.
- R9: Words 24, 25, 26 and 27 provide FIQ status, raw level, enable set and enable clear, with the same behaviour as words 16 to 19 but for a separate FIQ mask.
- R10: `irq` is high exactly when (level AND IRQ mask) was nonzero in the previous cycle. `fiq` follows the same rule with the FIQ mask.
- R11: A read of word 64+n, for n from 0 to 63, returns descriptor byte n zero-extended, and writes there are ignored. Byte 0 is 0x80 and byte 2 is 0x04. Bytes 32 to 63 are zero. Byte 31 gives the installed memory size in MB: 64 if the size is 256 or more, 32 if 128 or more, 16 if 64 or more, 4 if 32 or more, and 2 otherwise.
- R12: Any other word, including 0, 13 and all indices of 128 or more, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| waddr | input | ADDR_W | Word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| led | output | 1 | Status LED drive |
| remap | output | 1 | Boot flash moved away from address zero |
| sys_rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Registered IRQ request |
| fiq | output | 1 | Registered FIQ request |

## Verification
The bench builds the block with MEM_MB set to 256, so the size byte must take its top code of 64. The defaults stay at a 32-bit data path and a 10-bit word index, which means indices above the descriptor window can be reached and shown to read zero. The scoreboard sequence runs through the following cases:
- the lock, unlock and relock sequence around the config words;
- the reset pulse followed by a readback of the control word;
- the one-cycle lag of both interrupt lines as enables are set and cleared on each path separately.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  localparam int IDX_OSC     = 1;
  localparam int IDX_CTRL    = 3;
  localparam int IDX_LOCK    = 5;
  localparam int IDX_AUX     = 7;
  localparam int IDX_SDRAM   = 8;
  localparam int IDX_INIT    = 9;
  localparam int IDX_FLA_SET = 12;
  localparam int IDX_FLA_CLR = 13;
  localparam int IDX_FLB_SET = 14;
  localparam int IDX_FLB_CLR = 15;
  localparam int IDX_IRQ_BASE = 16;
  localparam int IDX_FIQ_BASE = 24;
  localparam int IDX_SWI_SET = 20;
  localparam int IDX_SWI_CLR = 21;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_RST  = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;

  function automatic logic key_matches(logic [15:0] key);
    return key == UNLOCK_KEY;
  endfunction

  function automatic logic [7:0] size_code(int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] desc_byte(logic [5:0] n, int mb);
    case (n)
      6'd0:  return 8'd128;
      6'd1:  return 8'd8;
      6'd2:  return 8'd4;
      6'd3:  return 8'd11;
      6'd4:  return 8'd9;
      6'd5:  return 8'd1;
      6'd6:  return 8'd64;
      6'd8:  return 8'd2;
      6'd9:  return 8'hA0;
      6'd10: return 8'hA0;
      6'd13: return 8'd8;
      6'd15: return 8'd1;
      6'd16: return 8'h0E;
      6'd17: return 8'd4;
      6'd18: return 8'h1C;
      6'd19: return 8'd1;
      6'd20: return 8'd2;
      6'd21: return 8'h20;
      6'd22: return 8'hC0;
      6'd27: return 8'h30;
      6'd28: return 8'h28;
      6'd29: return 8'h30;
      6'd30: return 8'h28;
      6'd31: return size_code(mb);
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/cmr_cfg.sv
module cmr_cfg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [5:0]        widx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] osc_q,
  output logic [DATA_W-1:0] aux_q,
  output logic [DATA_W-1:0] sdram_q,
  output logic [DATA_W-1:0] init_q,
  output logic [15:0]       lock_q,
  output logic              key_ok,
  output logic [1:0]        ctrl_q,
  output logic [DATA_W-1:0] fla_q,
  output logic [DATA_W-1:0] flb_q,
  output logic              rst_pulse
);
  import cmr_pkg::*;

  logic hit_ctrl, cfg_we;
  assign key_ok   = key_matches(lock_q);
  assign hit_ctrl = we && (widx == 6'(IDX_CTRL));
  assign cfg_we   = we && key_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q     <= DATA_W'(OSC_RST);
      aux_q     <= DATA_W'(AUX_RST);
      sdram_q   <= DATA_W'(SDRAM_RST);
      init_q    <= DATA_W'(INIT_RST);
      lock_q    <= '0;
      ctrl_q    <= '0;
      fla_q     <= '0;
      flb_q     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= hit_ctrl && wdata[3];
      if (hit_ctrl) ctrl_q <= {wdata[2], wdata[0]};
      if (we && widx == 6'(IDX_LOCK)) lock_q <= wdata[15:0];
      if (cfg_we && widx == 6'(IDX_OSC))   osc_q   <= wdata;
      if (cfg_we && widx == 6'(IDX_AUX))   aux_q   <= wdata;
      if (cfg_we && widx == 6'(IDX_SDRAM)) sdram_q <= wdata;
      if (cfg_we && widx == 6'(IDX_INIT))  init_q  <= wdata;
      if (we && widx == 6'(IDX_FLA_SET)) fla_q <= fla_q | wdata;
      if (we && widx == 6'(IDX_FLA_CLR)) fla_q <= fla_q & ~wdata;
      if (we && widx == 6'(IDX_FLB_SET)) flb_q <= flb_q | wdata;
      if (we && widx == 6'(IDX_FLB_CLR)) flb_q <= flb_q & ~wdata;
    end
  end
endmodule

// File: rtl/cmr_intc.sv
module cmr_intc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [5:0]        widx,
  input  logic [DATA_W-1:0] wdata,
  output logic              lvl_q,
  output logic [DATA_W-1:0] irq_en,
  output logic [DATA_W-1:0] fiq_en,
  output logic              irq,
  output logic              fiq
);
  import cmr_pkg::*;

  localparam int NCH = 2;
  logic [DATA_W-1:0] en_q  [NCH];
  logic [NCH-1:0]    req_q;
  logic [DATA_W-1:0] lvl_vec;

  assign lvl_vec = {{(DATA_W-1){1'b0}}, lvl_q};

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else if (we && widx == 6'(IDX_SWI_SET) && wdata[0]) lvl_q <= 1'b1;
    else if (we && widx == 6'(IDX_SWI_CLR) && wdata[0]) lvl_q <= 1'b0;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = (ch == 0) ? IDX_IRQ_BASE : IDX_FIQ_BASE;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[ch]  <= '0;
        req_q[ch] <= 1'b0;
      end else begin
        req_q[ch] <= |(lvl_vec & en_q[ch]);
        if (we && widx == 6'(BASE + 2)) en_q[ch] <= en_q[ch] | wdata;
        if (we && widx == 6'(BASE + 3)) en_q[ch] <= en_q[ch] & ~wdata;
      end
    end
  end

  assign irq_en = en_q[0];
  assign fiq_en = en_q[1];
  assign irq    = req_q[0];
  assign fiq    = req_q[1];
endmodule

// File: rtl/cmr_desc.sv
module cmr_desc #(
  parameter int MEM_MB = 128
) (
  input  logic [5:0] entry,
  output logic [7:0] dbyte
);
  import cmr_pkg::*;
  assign dbyte = desc_byte(entry, MEM_MB);
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              led,
  output logic              remap,
  output logic              sys_rst_req,
  output logic              irq,
  output logic              fiq
);
  import cmr_pkg::*;

  localparam int PAGE_W = 6;
  localparam int HI_W   = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] widx;
  logic              in_regs, in_win, reg_we;
  logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, fla_q, flb_q;
  logic [DATA_W-1:0] irq_en, fiq_en, lvl_vec, rd_word;
  logic [15:0]       lock_q;
  logic [1:0]        ctrl_q;
  logic              key_ok, lvl_q;
  logic [7:0]        dbyte;

  assign widx    = waddr[PAGE_W-1:0];
  assign in_regs = (waddr[ADDR_W-1:PAGE_W] == HI_W'(0));
  assign in_win  = (waddr[ADDR_W-1:PAGE_W] == HI_W'(1));
  assign reg_we  = wr_en && in_regs;
  assign lvl_vec = {{(DATA_W-1){1'b0}}, lvl_q};

  cmr_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(widx), .wdata(wdata),
    .osc_q(osc_q), .aux_q(aux_q), .sdram_q(sdram_q), .init_q(init_q),
    .lock_q(lock_q), .key_ok(key_ok), .ctrl_q(ctrl_q),
    .fla_q(fla_q), .flb_q(flb_q), .rst_pulse(sys_rst_req)
  );

  cmr_intc #(.DATA_W(DATA_W)) u_intc (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(widx), .wdata(wdata),
    .lvl_q(lvl_q), .irq_en(irq_en), .fiq_en(fiq_en), .irq(irq), .fiq(fiq)
  );

  cmr_desc #(.MEM_MB(MEM_MB)) u_desc (.entry(widx), .dbyte(dbyte));

  assign led   = ctrl_q[0];
  assign remap = ctrl_q[1];

  always_comb begin
    rd_word = '0;
    if (in_win) begin
      rd_word = {{(DATA_W-8){1'b0}}, dbyte};
    end else if (in_regs) begin
      case (int'(widx))
        IDX_OSC:          rd_word = osc_q;
        IDX_CTRL:         rd_word = {{(DATA_W-3){1'b0}}, ctrl_q[1], 1'b0, ctrl_q[0]};
        IDX_LOCK:         rd_word = {{(DATA_W-17){1'b0}}, key_ok, lock_q};
        IDX_AUX:          rd_word = aux_q;
        IDX_SDRAM:        rd_word = sdram_q;
        IDX_INIT:         rd_word = init_q;
        IDX_FLA_SET:      rd_word = fla_q;
        IDX_FLB_SET:      rd_word = flb_q;
        IDX_IRQ_BASE:     rd_word = lvl_vec & irq_en;
        IDX_IRQ_BASE + 1: rd_word = lvl_vec;
        IDX_IRQ_BASE + 2: rd_word = irq_en;
        IDX_SWI_SET:      rd_word = lvl_vec;
        IDX_FIQ_BASE:     rd_word = lvl_vec & fiq_en;
        IDX_FIQ_BASE + 1: rd_word = lvl_vec;
        IDX_FIQ_BASE + 2: rd_word = fiq_en;
        default:          rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/cmr_chk.sv
module cmr_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] waddr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              led,
  input logic              remap,
  input logic              sys_rst_req,
  input logic              irq,
  input logic              fiq,
  input logic              key_ok,
  input logic [DATA_W-1:0] osc_q,
  input logic [15:0]       lock_q,
  input logic              lvl_q,
  input logic [DATA_W-1:0] irq_en,
  input logic [DATA_W-1:0] fiq_en
);
  logic wr_ctrl, wr_osc, wr_lock, rd_far, irq_due, fiq_due;
  assign wr_ctrl = wr_en && (waddr == ADDR_W'(3));
  assign wr_osc  = wr_en && (waddr == ADDR_W'(1));
  assign wr_lock = wr_en && (waddr == ADDR_W'(5));
  assign rd_far  = rd_en && (waddr >= ADDR_W'(128));
  assign irq_due = lvl_q && irq_en[0];
  assign fiq_due = lvl_q && fiq_en[0];

  p_lock_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> (lock_q == $past(wdata[15:0])));
  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && !key_ok) |=> $stable(osc_q));
  p_ctrl_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (led == $past(wdata[0]) && remap == $past(wdata[2])));
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[3]) |=> sys_rst_req);
  p_rst_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && wdata[3]) |=> !sys_rst_req);
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_due |=> irq);
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_due |=> !irq);
  p_fiq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_due |=> fiq);
  p_fiq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_due |=> !fiq);
  p_far_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_far |=> (rdata == '0));
endmodule

bind cm_ctrl_regs cmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
  .wdata(wdata), .rdata(rdata), .led(led), .remap(remap),
  .sys_rst_req(sys_rst_req), .irq(irq), .fiq(fiq), .key_ok(key_ok),
  .osc_q(osc_q), .lock_q(lock_q), .lvl_q(lvl_q), .irq_en(irq_en),
  .fiq_en(fiq_en)
);

// File: tb/cm_ctrl_regs_tb.sv
module cm_ctrl_regs_tb;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int MB = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          led, remap, sys_rst_req, irq, fiq;

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_d = 1'b0;

  always #2 clk = ~clk;

  cm_ctrl_regs #(.DATA_W(DW), .ADDR_W(AW), .MEM_MB(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
    .wdata(wdata), .rdata(rdata), .led(led), .remap(remap),
    .sys_rst_req(sys_rst_req), .irq(irq), .fiq(fiq)
  );

  function automatic logic [7:0] exp_size(int mb);
    int lim[4] = '{256, 128, 64, 32};
    logic [7:0] code[4] = '{8'd64, 8'd32, 8'd16, 8'd4};
    for (int k = 0; k < 4; k++) if (mb >= lim[k]) return code[k];
    return 8'd2;
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = AW'(idx); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; waddr = AW'(idx);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read data %h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check({27'd0, led, remap, sys_rst_req, irq, fiq}, '0, "R1 outputs");
    rd(1, 32'h0100_0048, "R1 osc");
    rd(7, 32'h0007_FEFF, "R1 aux");
    rd(8, 32'h0001_1122, "R1 sdram");
    rd(9, 32'h0000_0112, "R1 init");
    rd(5, 32'h0, "R1 lock");
    rd(3, 32'h0, "R1 ctrl");
    rd(12, 32'h0, "R1 flags");
    rd(18, 32'h0, "R1 irq enables");
    // R3 locked writes ignored, R2 key storage
    wr(1, 32'hDEAD_BEEF);
    rd(1, 32'h0100_0048, "R3 osc locked");
    wr(5, 32'h0000_1234);
    rd(5, 32'h0000_1234, "R2 wrong key");
    wr(7, 32'h1111_1111);
    rd(7, 32'h0007_FEFF, "R3 aux wrong key");
    wr(5, 32'hFFFF_A05F);
    rd(5, 32'h0001_A05F, "R2 key match");
    wr(1, 32'hDEAD_BEEF);
    wr(7, 32'h1357_9BDF);
    wr(8, 32'h0000_0055);
    wr(9, 32'h0000_0077);
    rd(1, 32'hDEAD_BEEF, "R3 osc unlocked");
    rd(7, 32'h1357_9BDF, "R3 aux unlocked");
    rd(8, 32'h0000_0055, "R3 sdram unlocked");
    rd(9, 32'h0000_0077, "R3 init unlocked");
    wr(5, 32'h0);
    wr(8, 32'h0000_0099);
    rd(8, 32'h0000_0055, "R3 sdram relocked");
    // R4 control
    wr(3, 32'hFFFF_FFF7);
    check({31'd0, led}, 32'd1, "R4 led set");
    check({31'd0, remap}, 32'd1, "R4 remap set");
    rd(3, 32'h5, "R4 ctrl readback");
    wr(3, 32'h4);
    check({30'd0, led, remap}, 32'd1, "R4 led clear remap held");
    // R5 reset pulse
    check({31'd0, sys_rst_req}, 32'd0, "R5 idle");
    wr(3, 32'h8);
    check({31'd0, sys_rst_req}, 32'd1, "R5 pulse high");
    @(negedge clk);
    check({31'd0, sys_rst_req}, 32'd0, "R5 pulse one cycle");
    rd(3, 32'h0, "R5 bit3 reads zero");
    check({30'd0, led, remap}, 32'd0, "R4 cleared by bit3 write");
    // R6 flags
    wr(12, 32'hF0); wr(12, 32'h0F);
    rd(12, 32'hFF, "R6 flag set OR");
    wr(13, 32'h3C);
    rd(12, 32'hC3, "R6 flag clear");
    wr(14, 32'hA5); wr(15, 32'h05);
    rd(14, 32'hA0, "R6 second flag set");
    rd(12, 32'hC3, "R6 sets independent");
    // R7 / R8 / R10 IRQ path
    wr(18, 32'h10); wr(18, 32'h01);
    rd(18, 32'h11, "R7 enable OR");
    wr(20, 32'hFFFF_FFFE);
    rd(17, 32'h0, "R8 bit0 clear ignored");
    check({31'd0, irq}, 32'd0, "R10 irq idle");
    wr(20, 32'h1);
    check({31'd0, irq}, 32'd0, "R10 irq lag");
    @(negedge clk);
    check({31'd0, irq}, 32'd1, "R10 irq asserted");
    check({31'd0, fiq}, 32'd0, "R10 fiq masked");
    rd(16, 32'h1, "R7 irq status");
    rd(17, 32'h1, "R7 raw level");
    rd(20, 32'h1, "R8 soft readback");
    // R9 FIQ path
    rd(24, 32'h0, "R9 fiq status masked");
    wr(26, 32'h3);
    rd(26, 32'h3, "R9 fiq enables");
    rd(24, 32'h1, "R9 fiq status");
    rd(25, 32'h1, "R9 fiq raw");
    check({31'd0, fiq}, 32'd1, "R10 fiq asserted");
    wr(19, 32'h1);
    rd(18, 32'h10, "R7 enable clear");
    check({31'd0, irq}, 32'd0, "R10 irq dropped");
    wr(27, 32'h1);
    rd(26, 32'h2, "R9 fiq enable clear");
    check({31'd0, fiq}, 32'd0, "R10 fiq dropped");
    wr(26, 32'h1);
    wr(21, 32'hFFFF_FFFE);
    rd(17, 32'h1, "R8 clear without bit0 ignored");
    wr(21, 32'h1);
    rd(17, 32'h0, "R8 soft clear");
    @(negedge clk);
    check({30'd0, irq, fiq}, 32'd0, "R10 both low after clear");
    // R11 descriptor window
    rd(64, 32'h80, "R11 byte0");
    rd(66, 32'h04, "R11 byte2");
    rd(64 + 31, {24'd0, exp_size(MB)}, "R11 size byte");
    rd(64 + 40, 32'h0, "R11 byte40");
    rd(127, 32'h0, "R11 byte63");
    wr(64, 32'hFF);
    rd(64, 32'h80, "R11 write ignored");
    // R12 unimplemented
    rd(0, 32'h0, "R12 word0");
    rd(13, 32'h0, "R12 word13");
    wr(40, 32'hFFFF_FFFF);
    rd(40, 32'h0, "R12 word40");
    rd(200, 32'h0, "R12 beyond window");
    wr(128 + 3, 32'h5);
    check({30'd0, led, remap}, 32'd0, "R12 aliased ctrl ignored");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule